// File: doc/BRIEF.md
# Complementary PWM Pin Override Gate

This block sits between a three-channel complementary PWM generator and the six output pins. Each channel has a high-side and a low-side drive signal. A small 8-bit control register marks each pin as either driven by the modulator or held at its safe off level. The per-pin override takes effect only while a global enable input is high. A fault input forces every pin to its off level at once. The fault stays latched until software clears it with a strobe, and that strobe works only after the fault input has gone low.

The two off levels are set per side by parameters, so a pin may be off when driven low or when driven high. Reading the register does not return the stored override bits. It returns the pin levels themselves, taken through a two-stage synchronizer. A hold-request output goes high whenever all three high-side pins, or all three low-side pins, are in their on state. A current-sense sample-and-hold stage uses it to freeze its input.

Top module: `pwm_pin_gate`

## Requirements
- R1: A synchronous reset clears the override register and the fault latch. It sets every high-side pin to HI_OFF and every low-side pin to LO_OFF, and drives hold_req and rd_data to 0.
- R2: The override bit layout is bit 2*i for the high-side pin of channel i and bit 2*i+1 for the low-side pin of channel i. While ovr_en is 1, a set bit holds that pin at its off level from the edge after the register holds the bit.
- R3: With ovr_en at 1 and a clear bit, the pin takes the value its PWM input had before the previous clock edge (one register stage).
- R4: While ovr_en is 0, all six pins follow their PWM inputs, whatever the register holds.
- R5: A forced high-side pin drives HI_OFF and a forced low-side pin drives LO_OFF. In the bench, HI_OFF=0 and LO_OFF=1.
- R6: fault_in at 1 before an edge makes all six pins show their off levels after that edge, whatever ovr_en and the register hold.
- R7: The fault stays latched after fault_in falls. flt_clr clears it only in a cycle where fault_in is 0. If flt_clr arrives while fault_in is 1, it has no effect.
- R8: rd_en loads rd_data. Bits 5:0 take the pin levels, using the bit layout of R2, as they stood two edges before the loading edge. Bits 7:6 read 0. The written override value is never returned.
- R9: hold_req is 1 in exactly the cycles where all high-side pins differ from HI_OFF, or all low-side pins differ from LO_OFF.
- R10: The PWM inputs keep being sampled while a pin is forced. When the force ends, the pin shows the current PWM value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_en | input | 1 | Global enable for per-pin overrides |
| wr_en | input | 1 | Write strobe for the override register |
| wr_data | input | 8 | Write data; bits 7:6 reserved |
| rd_en | input | 1 | Read strobe; loads rd_data |
| rd_data | output | 8 | Synchronized pin levels, bits 7:6 zero |
| fault_in | input | 1 | Fault detect, sets the latch |
| flt_clr | input | 1 | Fault-clear strobe |
| pwm_hi | input | 3 | High-side PWM drive per channel |
| pwm_lo | input | 3 | Low-side PWM drive per channel |
| pin_hi | output | 3 | High-side pins |
| pin_lo | output | 3 | Low-side pins |
| hold_req | output | 1 | Current-sense hold request |

## Verification
A corrupted override register shows as a pin that holds its off level, or fails to, one edge after the stored value matters. A stuck fault latch shows as pins still forced in the cycle after a valid clear. A slipped synchronizer stage shows as rd_data holding the pin picture from the wrong edge on the next read. Because hold_req is computed from the pin values of the same edge, a wrong pin state also shows on hold_req in that same cycle. The reference model tracks all of these state bits and compares every output on every cycle, so each such error is caught within one or two cycles.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int REG_W = 8;

  function automatic int hi_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int lo_pos(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/pwm_gate_regs.sv
module pwm_gate_regs #(
  parameter int REG_W = 8,
  parameter int OVR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [OVR_W-1:0] ovr_q
);
  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[REG_W-1:OVR_W];

  always_ff @(posedge clk) begin
    if (rst)
      ovr_q <= '0;
    else if (wr_en)
      ovr_q <= wr_data[OVR_W-1:0];
  end
endmodule

// File: rtl/pwm_gate_fault.sv
module pwm_gate_fault (
  input  logic clk,
  input  logic rst,
  input  logic fault_in,
  input  logic flt_clr,
  output logic flt_q,
  output logic force_off
);
  always_ff @(posedge clk) begin
    if (rst)
      flt_q <= 1'b0;
    else if (fault_in)
      flt_q <= 1'b1;
    else if (flt_clr)
      flt_q <= 1'b0;
  end

  assign force_off = fault_in | flt_q;
endmodule

// File: rtl/pwm_gate_drive.sv
module pwm_gate_drive
  import pwm_gate_pkg::*;
#(
  parameter int   NCH    = 3,
  parameter logic HI_OFF = 1'b0,
  parameter logic LO_OFF = 1'b0,
  localparam int  OVR_W  = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pwm_hi,
  input  logic [NCH-1:0]   pwm_lo,
  input  logic             force_off,
  input  logic             ovr_act,
  input  logic [OVR_W-1:0] ovr_mask,
  output logic [NCH-1:0]   pin_hi,
  output logic [NCH-1:0]   pin_lo,
  output logic             hold_req
);
  localparam logic [NCH-1:0] HI_OFF_V = {NCH{HI_OFF}};
  localparam logic [NCH-1:0] LO_OFF_V = {NCH{LO_OFF}};
  localparam logic [NCH-1:0] HI_ON_V  = {NCH{~HI_OFF}};
  localparam logic [NCH-1:0] LO_ON_V  = {NCH{~LO_OFF}};

  logic [NCH-1:0] hi_nx, lo_nx;
  logic           hold_nx;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic kill_hi, kill_lo;
    assign kill_hi   = force_off | (ovr_act & ovr_mask[hi_pos(ch)]);
    assign kill_lo   = force_off | (ovr_act & ovr_mask[lo_pos(ch)]);
    assign hi_nx[ch] = kill_hi ? HI_OFF : pwm_hi[ch];
    assign lo_nx[ch] = kill_lo ? LO_OFF : pwm_lo[ch];
  end

  assign hold_nx = (hi_nx == HI_ON_V) | (lo_nx == LO_ON_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_hi   <= HI_OFF_V;
      pin_lo   <= LO_OFF_V;
      hold_req <= 1'b0;
    end else begin
      pin_hi   <= hi_nx;
      pin_lo   <= lo_nx;
      hold_req <= hold_nx;
    end
  end
endmodule

// File: rtl/pwm_gate_sync.sv
module pwm_gate_sync
  import pwm_gate_pkg::*;
#(
  parameter int  NCH    = 3,
  parameter int  REG_W  = 8,
  parameter int  STAGES = 2,
  localparam int OVR_W  = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pin_hi,
  input  logic [NCH-1:0]   pin_lo,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data
);
  logic [OVR_W-1:0] pin_vec;
  logic [OVR_W-1:0] stg [STAGES];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_pack
    assign pin_vec[hi_pos(ch)] = pin_hi[ch];
    assign pin_vec[lo_pos(ch)] = pin_lo[ch];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst)
        stg[s] <= '0;
      else if (s == 0)
        stg[s] <= pin_vec;
      else
        stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= {{(REG_W-OVR_W){1'b0}}, stg[STAGES-1]};
  end
endmodule

// File: rtl/pwm_pin_gate.sv
module pwm_pin_gate
  import pwm_gate_pkg::*;
#(
  parameter int   NCH    = 3,
  parameter logic HI_OFF = 1'b0,
  parameter logic LO_OFF = 1'b0,
  parameter int   SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovr_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             fault_in,
  input  logic             flt_clr,
  input  logic [NCH-1:0]   pwm_hi,
  input  logic [NCH-1:0]   pwm_lo,
  output logic [NCH-1:0]   pin_hi,
  output logic [NCH-1:0]   pin_lo,
  output logic             hold_req
);
  localparam int OVR_W = 2 * NCH;

  logic [OVR_W-1:0] ovr_q;
  logic             flt_q;
  logic             force_off;

  pwm_gate_regs #(.REG_W(REG_W), .OVR_W(OVR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ovr_q(ovr_q)
  );

  pwm_gate_fault u_fault (
    .clk(clk), .rst(rst), .fault_in(fault_in), .flt_clr(flt_clr),
    .flt_q(flt_q), .force_off(force_off)
  );

  pwm_gate_drive #(.NCH(NCH), .HI_OFF(HI_OFF), .LO_OFF(LO_OFF)) u_drive (
    .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .force_off(force_off), .ovr_act(ovr_en), .ovr_mask(ovr_q),
    .pin_hi(pin_hi), .pin_lo(pin_lo), .hold_req(hold_req)
  );

  pwm_gate_sync #(.NCH(NCH), .REG_W(REG_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_hi(pin_hi), .pin_lo(pin_lo),
    .rd_en(rd_en), .rd_data(rd_data)
  );
endmodule

// File: rtl/pwm_pin_gate_chk.sv
module pwm_pin_gate_chk #(
  parameter int   NCH    = 3,
  parameter logic HI_OFF = 1'b0,
  parameter logic LO_OFF = 1'b0,
  parameter int   REG_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ovr_en,
  input logic             fault_in,
  input logic             flt_clr,
  input logic             flt_q,
  input logic [2*NCH-1:0] ovr_q,
  input logic [NCH-1:0]   pwm_hi,
  input logic [NCH-1:0]   pwm_lo,
  input logic [NCH-1:0]   pin_hi,
  input logic [NCH-1:0]   pin_lo,
  input logic             hold_req,
  input logic [REG_W-1:0] rd_data
);
  localparam logic [NCH-1:0] HOFF = {NCH{HI_OFF}};
  localparam logic [NCH-1:0] LOFF = {NCH{LO_OFF}};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pin_hi == HOFF && pin_lo == LOFF && !hold_req && rd_data == '0));

  a_r2_bit0_forces: assert property (@(posedge clk) disable iff (rst)
    (ovr_en && ovr_q[0]) |=> pin_hi[0] == HI_OFF);

  a_r4_follow: assert property (@(posedge clk) disable iff (rst)
    (!ovr_en && !fault_in && !flt_q) |=> (pin_hi == $past(pwm_hi) && pin_lo == $past(pwm_lo)));

  a_r6_fault_off: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> (pin_hi == HOFF && pin_lo == LOFF));

  a_r7_latch_keep: assert property (@(posedge clk) disable iff (rst)
    (fault_in || (flt_q && !flt_clr)) |=> flt_q);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:2*NCH] == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    hold_req == ((pin_hi == ~HOFF) || (pin_lo == ~LOFF)));
endmodule

bind pwm_pin_gate pwm_pin_gate_chk #(
  .NCH(NCH), .HI_OFF(HI_OFF), .LO_OFF(LO_OFF), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst(rst), .ovr_en(ovr_en), .fault_in(fault_in),
  .flt_clr(flt_clr), .flt_q(flt_q), .ovr_q(ovr_q), .pwm_hi(pwm_hi),
  .pwm_lo(pwm_lo), .pin_hi(pin_hi), .pin_lo(pin_lo),
  .hold_req(hold_req), .rd_data(rd_data)
);

// File: tb/sim_pwm_pin_gate.sv
`timescale 1ns/1ps
module sim_pwm_pin_gate;
  localparam logic HI = 1'b0;
  localparam logic LO = 1'b1;

  logic clk = 0, rst = 1;
  logic ovr_en = 0, wr_en = 0, rd_en = 0, fault_in = 0, flt_clr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] pwm_hi = 0, pwm_lo = 0;
  logic [7:0] rd_data;
  logic [2:0] pin_hi, pin_lo;
  logic hold_req;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  pwm_pin_gate #(.NCH(3), .HI_OFF(HI), .LO_OFF(LO)) u0 (
    .clk(clk), .rst(rst), .ovr_en(ovr_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fault_in(fault_in), .flt_clr(flt_clr),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pin_hi(pin_hi), .pin_lo(pin_lo),
    .hold_req(hold_req)
  );

  // behavioural reference
  logic [2:0] m_h, m_l;
  logic       m_hold, m_flt;
  logic [5:0] m_ovr;
  logic [7:0] m_rd;
  logic [5:0] sq[$];

  function automatic logic [5:0] pack(input logic [2:0] h, input logic [2:0] l);
    logic [5:0] v;
    for (int i = 0; i < 3; i++) begin
      v[2*i]   = h[i];
      v[2*i+1] = l[i];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    logic [2:0] nh, nl;
    logic [5:0] oldv;
    logic frc;
    if (rst) begin
      m_h = {3{HI}}; m_l = {3{LO}}; m_hold = 0; m_flt = 0; m_ovr = 0; m_rd = 0;
      sq = {6'd0, 6'd0};
    end else begin
      oldv = pack(m_h, m_l);
      frc = fault_in | m_flt;
      for (int i = 0; i < 3; i++) begin
        nh[i] = (frc || (ovr_en && m_ovr[2*i]))   ? HI : pwm_hi[i];
        nl[i] = (frc || (ovr_en && m_ovr[2*i+1])) ? LO : pwm_lo[i];
      end
      m_hold = (nh == {3{~HI}}) || (nl == {3{~LO}});
      if (rd_en) m_rd = {2'b00, sq[0]};
      void'(sq.pop_front());
      sq.push_back(oldv);
      if (fault_in) m_flt = 1;
      else if (flt_clr) m_flt = 0;
      if (wr_en) m_ovr = wr_data[5:0];
      m_h = nh; m_l = nl;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    chk({phase, " pin_hi"}, {5'd0, pin_hi}, {5'd0, m_h});
    chk({phase, " pin_lo"}, {5'd0, pin_lo}, {5'd0, m_l});
    chk({phase, " hold_req"}, {7'd0, hold_req}, {7'd0, m_hold});
    chk({phase, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rnd_pwm(input int n);
    for (int k = 0; k < n; k++) begin
      pwm_hi = 3'($urandom); pwm_lo = 3'($urandom); rd_en = 1'($urandom);
      tick();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    phase = "R1 reset";
    repeat (3) tick();
    rst = 0;
    chk("R1 pin_hi off", {5'd0, pin_hi}, 8'h00);
    chk("R1 pin_lo off", {5'd0, pin_lo}, 8'h07);
    chk("R1 rd_data", rd_data, 8'h00);

    phase = "R4 global off";
    ovr_en = 0; wr(8'h3F); rnd_pwm(20);

    phase = "R3 follow";
    ovr_en = 1; wr(8'h00); rnd_pwm(20);

    phase = "R2 bit walk";
    for (int b = 0; b < 6; b++) begin
      wr(8'(1 << b)); rnd_pwm(6);
    end
    pwm_hi = 3'b111; pwm_lo = 3'b000; wr(8'h01); tick();
    chk("R2 bit0 forces hi ch0", {5'd0, pin_hi}, 8'h06);
    wr(8'h08); tick();
    chk("R2 bit3 forces lo ch1", {5'd0, pin_lo}, 8'h02);

    phase = "R5 off levels";
    wr(8'h3F); tick();
    chk("R5 hi off", {5'd0, pin_hi}, 8'h00);
    chk("R5 lo off", {5'd0, pin_lo}, 8'h07);

    phase = "R10 keep running";
    pwm_hi = 3'b101; pwm_lo = 3'b010; rnd_pwm(5);
    pwm_hi = 3'b011; pwm_lo = 3'b100; wr(8'h00); tick();
    chk("R10 resume hi", {5'd0, pin_hi}, 8'h03);
    chk("R10 resume lo", {5'd0, pin_lo}, 8'h04);

    phase = "R9 hold";
    pwm_hi = 3'b111; pwm_lo = 3'b111; tick(); tick();
    chk("R9 all hi on", {7'd0, hold_req}, 8'h01);
    pwm_hi = 3'b011; pwm_lo = 3'b000; tick(); tick();
    chk("R9 all lo on", {7'd0, hold_req}, 8'h01);
    pwm_lo = 3'b001; tick(); tick();
    chk("R9 neither", {7'd0, hold_req}, 8'h00);

    phase = "R6 fault";
    pwm_hi = 3'b111; pwm_lo = 3'b000; fault_in = 1; tick(); fault_in = 0;
    chk("R6 hi forced", {5'd0, pin_hi}, 8'h00);
    chk("R6 lo forced", {5'd0, pin_lo}, 8'h07);
    phase = "R7 latch";
    rnd_pwm(4);
    fault_in = 1; flt_clr = 1; tick(); fault_in = 0; flt_clr = 0; tick();
    chk("R7 clear during fault ignored", {5'd0, pin_hi}, 8'h00);
    pwm_hi = 3'b111; flt_clr = 1; tick(); flt_clr = 0; tick();
    chk("R7 cleared resumes", {5'd0, pin_hi}, 8'h07);

    phase = "R8 readback";
    ovr_en = 0; wr(8'hFF); rnd_pwm(20);
    chk("R8 reserved bits", {6'd0, rd_data[7:6]}, 8'h00);

    phase = "R2 R6 R7 mixed";
    for (int k = 0; k < 300; k++) begin
      ovr_en = 1'($urandom); fault_in = ($urandom % 20) == 0;
      flt_clr = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) begin wr_en = 1; wr_data = 8'($urandom); end
      pwm_hi = 3'($urandom); pwm_lo = 3'($urandom); rd_en = 1'($urandom);
      tick();
      wr_en = 0;
    end
    fault_in = 0; flt_clr = 0;
    tick();
    summary();
    $finish;
  end
endmodule